// File: doc/BRIEF.md
# DMA Controller Programming Port

This block is the processor-side register file of a four-channel DMA controller. Software reaches it through 8-bit I/O writes and reads on a byte-wide port address. It holds a 16-bit start address and a 16-bit transfer count for each channel, a mode byte for each channel, a channel mask, a global disable bit and an 8-bit page register for each channel. The page register extends the channel address to 24 bits, so every transfer stays within the lowest 16 MB.

The 16-bit address and count values pass through a single 8-bit port per value. A shared byte-pointer flip-flop chooses the low or high half. Software first resets the pointer with a write of any data to the pointer-reset port. It then moves the low byte and after that the high byte. Every access to an address or count port flips the pointer.

Masking uses an encoded write that names one channel and whether to set or clear its bit. The disable bit in the command port stops all channels at once and leaves the mask alone. The data-moving engine reads the resulting state from the flattened outputs of this block.

Top module: `dma_prog_port`

## Requirements
- R1: After reset, all four mask bits are 1, the byte pointer is low (0), the disable bit is 0, and every mode, address, count and page register is 0.
- R2: A write to port 2n (address, channel n) or 2n+1 (count, channel n), for n = 0..3, loads the byte selected by the pointer into both the base copy and the current copy: bits 7:0 when the pointer is 0 and bits 15:8 when it is 1. The pointer then flips.
- R3: A write to port 0x0C, with any data, sets the byte pointer to 0.
- R4: A read of port 2n or 2n+1 returns, in the same cycle, the byte of the current copy selected by the pointer. The pointer then flips.
- R5: A write to port 0x0A sets the mask bit of channel wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0. The other mask bits keep their values.
- R6: A write to port 0x0B stores wdata[7:2] as the 6-bit mode of channel wdata[1:0]. The fields are: bits 1:0 the transfer type (wdata[3:2]), bit 2 autoinit (wdata[4]), bit 3 address decrement (wdata[5]) and bits 5:4 the mode (wdata[7:6]).
- R7: Page registers sit at 0x87, 0x83, 0x81 and 0x82 for channels 0, 1, 2 and 3. They are writable and readable. The physical address output of each channel is {page, current address}.
- R8: The transfer length output of each channel is the stored count plus one, 17 bits wide. A count of 0xFFFF gives 0x10000.
- R9: Bit 2 of a write to port 0x08 sets the disable bit. chan_active is ~mask while the bit is 0 and all zeros while it is 1. Writing port 0x08 never changes the mask.
- R10: Writes to any other port change no state. Reads from any other port, and rdata whenever rd_en is low, are 0. Accesses to other ports do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | I/O write strobe |
| rd_en | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| mask | output | 4 | Channel mask bits |
| dma_disable | output | 1 | Global disable bit |
| chan_active | output | 4 | Channels unmasked and not disabled |
| byte_ptr_hi | output | 1 | Byte pointer state |
| mode_flat | output | 24 | Channel n mode in bits 6n+5:6n |
| base_addr_flat | output | 64 | Base address, channel n in bits 16n+15:16n |
| base_cnt_flat | output | 64 | Base count, channel n in bits 16n+15:16n |
| phys_addr_flat | output | 96 | {page, current address}, channel n in bits 24n+23:24n |
| xfer_len_flat | output | 68 | Count plus one, channel n in bits 17n+16:17n |

## Verification
The bench runs a long random mix of port accesses. Reads and writes fall unevenly between the pointer-reset port and the address and count ports, so the pointer is often left in the high state before a new access. A design that failed to toggle the pointer, or toggled it on reads only, would place bytes in the wrong half. Mask writes carry random junk in the upper bits, and command writes are interleaved with them. This exposes a design that decodes the wrong bits or clears the mask when the disable bit is set. Directed cases cover a count of 0xFFFF, where a 16-bit length would wrap to zero, and reads of the unused ports and the gaps between page ports, where a loose decoder would return stale data or move the pointer.

// File: rtl/dma_prog_port.sv
module dma_prog_port #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PW  = 8,
  parameter int MW  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [7:0]               io_addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NCH-1:0]           mask,
  output logic                     dma_disable,
  output logic [NCH-1:0]           chan_active,
  output logic                     byte_ptr_hi,
  output logic [NCH*MW-1:0]        mode_flat,
  output logic [NCH*AW-1:0]        base_addr_flat,
  output logic [NCH*AW-1:0]        base_cnt_flat,
  output logic [NCH*(AW+PW)-1:0]   phys_addr_flat,
  output logic [NCH*(AW+1)-1:0]    xfer_len_flat
);
  localparam int CW = $clog2(NCH);
  localparam logic [7:0] P_CMD   = 8'h08;
  localparam logic [7:0] P_MASK1 = 8'h0A;
  localparam logic [7:0] P_MODE  = 8'h0B;
  localparam logic [7:0] P_FFRST = 8'h0C;

  logic [AW-1:0] base_a [NCH];
  logic [AW-1:0] cur_a  [NCH];
  logic [AW-1:0] base_c [NCH];
  logic [AW-1:0] cur_c  [NCH];
  logic [MW-1:0] mode_r [NCH];
  logic [PW-1:0] page_r [NCH];

  logic          is_ac, is_cnt, pg_hit;
  logic [CW-1:0] ac_ch, pg_idx, sel_ch;

  assign is_ac  = (io_addr < 8'(2*NCH));
  assign is_cnt = io_addr[0];
  assign ac_ch  = io_addr[CW:1];
  assign sel_ch = wdata[CW-1:0];

  always_comb begin
    pg_hit = 1'b1;
    pg_idx = '0;
    case (io_addr)
      8'h87: pg_idx = CW'(0);
      8'h83: pg_idx = CW'(1);
      8'h81: pg_idx = CW'(2);
      8'h82: pg_idx = CW'(3);
      default: pg_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask        <= '1;
      dma_disable <= 1'b0;
      byte_ptr_hi <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        cur_a[i]  <= '0;
        base_c[i] <= '0;
        cur_c[i]  <= '0;
        mode_r[i] <= '0;
        page_r[i] <= '0;
      end
    end else begin
      if ((wr_en || rd_en) && is_ac)
        byte_ptr_hi <= ~byte_ptr_hi;
      if (wr_en) begin
        if (is_ac) begin
          if (is_cnt) begin
            if (byte_ptr_hi) begin
              base_c[ac_ch][15:8] <= wdata;
              cur_c[ac_ch][15:8]  <= wdata;
            end else begin
              base_c[ac_ch][7:0]  <= wdata;
              cur_c[ac_ch][7:0]   <= wdata;
            end
          end else begin
            if (byte_ptr_hi) begin
              base_a[ac_ch][15:8] <= wdata;
              cur_a[ac_ch][15:8]  <= wdata;
            end else begin
              base_a[ac_ch][7:0]  <= wdata;
              cur_a[ac_ch][7:0]   <= wdata;
            end
          end
        end else if (pg_hit) begin
          page_r[pg_idx] <= wdata;
        end else begin
          case (io_addr)
            P_CMD:   dma_disable <= wdata[2];
            P_MASK1: mask[sel_ch] <= wdata[2];
            P_MODE:  mode_r[sel_ch] <= wdata[7:2];
            P_FFRST: byte_ptr_hi <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  logic [AW-1:0] rd_word;
  assign rd_word = is_cnt ? cur_c[ac_ch] : cur_a[ac_ch];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (is_ac)       rdata = byte_ptr_hi ? rd_word[15:8] : rd_word[7:0];
      else if (pg_hit) rdata = page_r[pg_idx];
    end
  end

  assign chan_active = dma_disable ? '0 : ~mask;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign mode_flat[g*MW +: MW]                 = mode_r[g];
    assign base_addr_flat[g*AW +: AW]            = base_a[g];
    assign base_cnt_flat[g*AW +: AW]             = base_c[g];
    assign phys_addr_flat[g*(AW+PW) +: (AW+PW)]  = {page_r[g], cur_a[g]};
    assign xfer_len_flat[g*(AW+1) +: (AW+1)]     = {1'b0, base_c[g]} + 1'b1;
  end

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_addr == P_FFRST) |=> !byte_ptr_hi); // R3
  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && is_ac) |=> (byte_ptr_hi != $past(byte_ptr_hi))); // R2
  AST_CMD_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_addr == P_CMD) |=> $stable(mask)); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_addr == P_MASK1 && wdata[2]) |=> mask[$past(wdata[1:0])]); // R5
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_ac && !pg_hit) |-> (rdata == 8'h00)); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00)); // R10
endmodule

// File: tb/tb_dma_prog_port.sv
module tb_dma_prog_port;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] io_addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic [3:0] mask, chan_active;
  logic dma_disable, byte_ptr_hi;
  logic [23:0] mode_flat;
  logic [63:0] base_addr_flat, base_cnt_flat;
  logic [95:0] phys_addr_flat;
  logic [67:0] xfer_len_flat;

  int checks = 0, errors = 0;

  dma_prog_port dut (.clk, .rst_n, .wr_en, .rd_en, .io_addr, .wdata, .rdata,
    .mask, .dma_disable, .chan_active, .byte_ptr_hi, .mode_flat,
    .base_addr_flat, .base_cnt_flat, .phys_addr_flat, .xfer_len_flat);

  always #4 clk = ~clk;

  logic [15:0] m_a [4];
  logic [15:0] m_c [4];
  logic [5:0]  m_mode [4];
  logic [7:0]  m_pg [4];
  logic [3:0]  m_mask;
  logic        m_dis, m_ptr;

  function automatic int page_ch(input logic [7:0] a);
    case (a)
      8'h87: return 0;
      8'h83: return 1;
      8'h81: return 2;
      8'h82: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [15:0] w;
    if (a < 8) begin
      w = a[0] ? m_c[a[2:1]] : m_a[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (page_ch(a) >= 0) return m_pg[page_ch(a)];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a < 8) begin
      if (a[0]) begin
        if (m_ptr) m_c[a[2:1]][15:8] = d; else m_c[a[2:1]][7:0] = d;
      end else begin
        if (m_ptr) m_a[a[2:1]][15:8] = d; else m_a[a[2:1]][7:0] = d;
      end
      m_ptr = ~m_ptr;
    end else if (page_ch(a) >= 0) m_pg[page_ch(a)] = d;
    else case (a)
      8'h08: m_dis = d[2];
      8'h0A: m_mask[d[1:0]] = d[2];
      8'h0B: m_mode[d[1:0]] = d[7:2];
      8'h0C: m_ptr = 0;
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 mask"}, 128'(mask), 128'(m_mask));
    chk({tag, " R9 disable/active"}, 128'({dma_disable, chan_active}),
        128'({m_dis, m_dis ? 4'h0 : ~m_mask}));
    chk({tag, " R2 R3 ptr"}, 128'(byte_ptr_hi), 128'(m_ptr));
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R6 mode"}, 128'(mode_flat[i*6 +: 6]), 128'(m_mode[i]));
      chk({tag, " R2 base addr"}, 128'(base_addr_flat[i*16 +: 16]), 128'(m_a[i]));
      chk({tag, " R2 base count"}, 128'(base_cnt_flat[i*16 +: 16]), 128'(m_c[i]));
      chk({tag, " R7 phys addr"}, 128'(phys_addr_flat[i*24 +: 24]), 128'({m_pg[i], m_a[i]}));
      chk({tag, " R8 length"}, 128'(xfer_len_flat[i*17 +: 17]), 128'({1'b0, m_c[i]} + 17'd1));
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; io_addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk); rd_en = 1; io_addr = a;
    #1 chk({req, " read"}, 128'(rdata), 128'(exp_read(a)));
    @(negedge clk); rd_en = 0;
    if (a < 8) m_ptr = ~m_ptr;
  endtask

  localparam logic [7:0] UNUSED [8] = '{8'h09, 8'h0D, 8'h0E, 8'h0F, 8'h80, 8'h84, 8'h85, 8'h20};

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin m_a[i] = 0; m_c[i] = 0; m_mode[i] = 0; m_pg[i] = 0; end
    m_mask = 4'hF; m_dis = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("reset R1");
    chk("R10 idle rdata", 128'(rdata), 128'(0));

    // directed: channel 2 setup, count 0x23FF
    wr(8'h0A, 8'h06); wr(8'h0C, 8'hFF);
    wr(8'h04, 8'h00); wr(8'h04, 8'h10);
    wr(8'h05, 8'hFF); wr(8'h05, 8'h23);
    wr(8'h81, 8'h00); wr(8'h0B, 8'h5A); wr(8'h0A, 8'h02);
    check_all("ch2 setup R2 R6");
    chk("R8 0x23FF length", 128'(xfer_len_flat[2*17 +: 17]), 128'(17'h2400));
    // directed: count 0xFFFF on channel 3
    wr(8'h0C, 8'h00); wr(8'h07, 8'hFF); wr(8'h07, 8'hFF);
    chk("R8 full length", 128'(xfer_len_flat[3*17 +: 17]), 128'(17'h10000));
    // read back with pointer low then high
    wr(8'h0C, 8'h55); rd(8'h04, "R4 low"); rd(8'h04, "R4 high");
    // pointer left high, then reset
    rd(8'h05, "R4"); wr(8'h0C, 8'h00); check_all("R3 after reset write");
    // disable keeps mask
    wr(8'h08, 8'h04); check_all("R9 disabled");
    wr(8'h0A, 8'hF9); check_all("R5 junk bits"); wr(8'h08, 8'h00); check_all("R9 enabled");
    // unused ports
    for (int i = 0; i < 8; i++) begin
      wr(UNUSED[i], 8'hA5); rd(UNUSED[i], "R10 unused"); check_all("R10 untouched");
    end
    rd(8'h81, "R7 page");

    for (int n = 0; n < 600; n++) begin
      int k; logic [7:0] a, d;
      k = $urandom_range(0, 9); d = 8'($urandom);
      case (k)
        0, 1, 2: a = 8'($urandom_range(0, 7));
        3: a = 8'h0A;
        4: a = 8'h0B;
        5: a = 8'h0C;
        6: a = 8'h08;
        7: a = (n % 4 == 0) ? 8'h87 : (n % 4 == 1) ? 8'h83 : (n % 4 == 2) ? 8'h81 : 8'h82;
        default: a = UNUSED[$urandom_range(0, 7)];
      endcase
      if ($urandom_range(0, 2) == 0) rd(a, "R4 R7 R10 random");
      else wr(a, d);
      if (n % 10 == 0) check_all("random");
    end
    check_all("final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule